// File: doc/BRIEF.md
# Loop Filter Selection Controller

This block picks the coefficient set that a power-factor-correction control loop runs with. Two current-loop sets are chosen by line class, one for low line and one for high line, and a fast voltage set takes over while the output voltage is recovering from a transient. The filter arithmetic lives elsewhere. This block only produces the two selection signals that steer it.

The line class is sampled once per rectified half cycle, each time a measured RMS value arrives with its strobe. A change of class must hold for eight consecutive half cycles, which is four full line cycles. The new line filter then takes effect only on the next zero crossing. The fast loop is also entered and left only on zero crossings, so coefficients never change in the middle of a half cycle. A millisecond watchdog stops the fast loop from lasting forever when the output never settles back into its band.

Top module: `loop_filter_select`

## Requirements
- R1: While reset is asserted and after it is released, `high_line_sel` is 0 (low-line filter) and `fast_active` is 0 until inputs act on the block.
- R2: The line class is taken only on cycles where `rms_valid` is 1. The class is high when `rms_value >= line_thresh` (equality counts as high). Changes of `rms_value` without the strobe have no effect.
- R3: A strobe whose class differs from the current selection advances a count. The selection stays unchanged until eight such strobes have arrived in a row. The count saturates at eight.
- R4: A strobe whose class matches the current selection clears the count, which cancels any pending change, including one that has already reached eight.
- R5: Once eight differing strobes have arrived, `high_line_sel` inverts on the clock edge that samples the next `zero_cross` pulse, and never before. On that edge any strobe is ignored and the count restarts from zero.
- R6: With `fast_en` at 1, a `transient` pulse arms the fast loop. `fast_active` rises on the edge that samples the next `zero_cross` pulse (a zero crossing on the same cycle as the transient does not count).
- R7: While the fast loop runs, `out_in_band` at 1 requests the exit. `fast_active` then falls on the edge that samples the next later `zero_cross`.
- R8: If `TIMEOUT_MS` (default 630) `ms_tick` pulses arrive during the fast loop without the output returning to its band, the exit is requested all the same, and `fast_active` falls on the next `zero_cross`. After 629 ticks a zero crossing leaves the fast loop running.
- R9: With `fast_en` at 0, `fast_active` is 0 from the next edge on, any pending entry is dropped, and transients have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rms_valid | input | 1 | One-cycle strobe per half line cycle qualifying `rms_value` |
| rms_value | input | RMS_W (12) | Measured RMS line value |
| line_thresh | input | RMS_W (12) | High/low line boundary |
| zero_cross | input | 1 | One-cycle pulse at each rectified-line zero crossing |
| out_in_band | input | 1 | Output voltage is inside the regulation band |
| transient | input | 1 | Load transient detected |
| fast_en | input | 1 | Allows the fast loop |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| high_line_sel | output | 1 | 1 selects the high-line current filter, 0 the low-line one |
| fast_active | output | 1 | 1 while the fast voltage filter is in use |

## Verification
On every cycle, the checker asserts that the line selection and the fast-loop flag change only on a zero crossing. It also asserts that the debounce count never passes eight, that no switch happens below that count, and that dropping the enable clears the fast flag on the next edge. Some behaviours can be shown only by the bench scenarios: cancelling a pending change with a matching strobe, treating a value equal to the threshold as high line, and the exact tick on which the 630 ms timeout takes effect. A behavioural reference model also tracks both outputs on every clock.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    FL_NORMAL = 2'd0,
    FL_ARM    = 2'd1,
    FL_FAST   = 2'd2,
    FL_LEAVE  = 2'd3
  } fl_state_e;
endpackage

// File: rtl/line_class_debounce.sv
module line_class_debounce #(
  parameter int RMS_W          = 12,
  parameter int CONFIRM_HALVES = 8,
  localparam int CW            = $clog2(CONFIRM_HALVES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rms_valid,
  input  logic [RMS_W-1:0] rms_value,
  input  logic [RMS_W-1:0] line_thresh,
  input  logic             zero_cross,
  output logic             high_sel,
  output logic [CW-1:0]    cnt
);
  localparam logic [CW-1:0] CNT_FULL = CW'(CONFIRM_HALVES);

  logic          sel_q, sel_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          class_hi, armed, upd_en;

  assign class_hi = (rms_value >= line_thresh);
  assign armed    = (cnt_q == CNT_FULL);
  assign upd_en   = rms_valid | zero_cross;

  always_comb begin
    sel_d = sel_q;
    cnt_d = cnt_q;
    if (zero_cross && armed) begin
      sel_d = ~sel_q;
      cnt_d = '0;
    end else if (rms_valid) begin
      if (class_hi != sel_q) begin
        if (!armed) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign high_sel = sel_q;
  assign cnt      = cnt_q;
endmodule

// File: rtl/fast_timeout_timer.sv
module fast_timeout_timer #(
  parameter int TIMEOUT_MS = 630,
  localparam int TW        = $clog2(TIMEOUT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic ms_tick,
  output logic expired
);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_MS - 1);

  logic [TW-1:0] ms_q, ms_d;
  logic          cnt_en;

  assign cnt_en  = clr | (run & ms_tick);
  assign expired = run & ms_tick & (ms_q == LAST);

  always_comb begin
    if (clr) ms_d = '0;
    else     ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ms_q <= '0;
    else if (cnt_en) ms_q <= ms_d;
  end
endmodule

// File: rtl/fast_loop_fsm.sv
module fast_loop_fsm
  import lfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast_en,
  input  logic transient,
  input  logic zero_cross,
  input  logic out_in_band,
  input  logic expired,
  output logic enter_fast,
  output logic in_fast,
  output logic fast_active
);
  fl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!fast_en) begin
      st_d = FL_NORMAL;
    end else begin
      case (st_q)
        FL_NORMAL: if (transient) st_d = FL_ARM;
        FL_ARM:    if (zero_cross) st_d = FL_FAST;
        FL_FAST:   if (out_in_band || expired) st_d = FL_LEAVE;
        FL_LEAVE:  if (zero_cross) st_d = FL_NORMAL;
        default:   st_d = FL_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FL_NORMAL;
    else        st_q <= st_d;
  end

  assign enter_fast  = (st_q == FL_ARM) && zero_cross && fast_en;
  assign in_fast     = (st_q == FL_FAST);
  assign fast_active = (st_q == FL_FAST) || (st_q == FL_LEAVE);
endmodule

// File: rtl/loop_filter_select.sv
module loop_filter_select #(
  parameter int RMS_W          = 12,
  parameter int CONFIRM_HALVES = 8,
  parameter int TIMEOUT_MS     = 630,
  localparam int CW            = $clog2(CONFIRM_HALVES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rms_valid,
  input  logic [RMS_W-1:0] rms_value,
  input  logic [RMS_W-1:0] line_thresh,
  input  logic             zero_cross,
  input  logic             out_in_band,
  input  logic             transient,
  input  logic             fast_en,
  input  logic             ms_tick,
  output logic             high_line_sel,
  output logic             fast_active
);
  logic          rst_meta, rst_core_n;
  logic [CW-1:0] line_cnt;
  logic          enter_fast, in_fast, expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  line_class_debounce #(
    .RMS_W(RMS_W), .CONFIRM_HALVES(CONFIRM_HALVES)
  ) u_line (
    .clk(clk), .rst_n(rst_core_n), .rms_valid(rms_valid),
    .rms_value(rms_value), .line_thresh(line_thresh),
    .zero_cross(zero_cross), .high_sel(high_line_sel), .cnt(line_cnt)
  );

  fast_timeout_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_tmo (
    .clk(clk), .rst_n(rst_core_n), .clr(enter_fast), .run(in_fast),
    .ms_tick(ms_tick), .expired(expired)
  );

  fast_loop_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .fast_en(fast_en), .transient(transient),
    .zero_cross(zero_cross), .out_in_band(out_in_band), .expired(expired),
    .enter_fast(enter_fast), .in_fast(in_fast), .fast_active(fast_active)
  );
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
  parameter int CONFIRM_HALVES = 8,
  localparam int CW            = $clog2(CONFIRM_HALVES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zero_cross,
  input logic          fast_en,
  input logic          high_line_sel,
  input logic          fast_active,
  input logic [CW-1:0] line_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= CW'(CONFIRM_HALVES)); // R3
  AST_NO_EARLY_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt != CW'(CONFIRM_HALVES)) |=> $stable(high_line_sel)); // R3
  AST_LINE_AT_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_cross |=> $stable(high_line_sel)); // R5
  AST_ENTRY_AT_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_active && !zero_cross) |=> !fast_active); // R6
  AST_EXIT_AT_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_active && fast_en && !zero_cross) |=> fast_active); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> !fast_active); // R9
endmodule

bind loop_filter_select lfs_checker #(.CONFIRM_HALVES(CONFIRM_HALVES)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .zero_cross(zero_cross), .fast_en(fast_en),
  .high_line_sel(high_line_sel), .fast_active(fast_active), .line_cnt(line_cnt)
);

// File: tb/loop_filter_select_test.sv
`timescale 1ns/1ps
module loop_filter_select_test;
  localparam int W   = 12;
  localparam int TMO = 630;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rms_valid = 1'b0;
  logic [W-1:0] rms_value = '0;
  logic [W-1:0] line_thresh = 12'd100;
  logic zero_cross = 1'b0, out_in_band = 1'b0, transient = 1'b0;
  logic fast_en = 1'b0, ms_tick = 1'b0;
  logic high_line_sel, fast_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_high;
  int m_cnt, m_mode, m_ms;

  always #5 clk = ~clk;

  loop_filter_select uut (
    .clk(clk), .rst_n(rst_n), .rms_valid(rms_valid), .rms_value(rms_value),
    .line_thresh(line_thresh), .zero_cross(zero_cross), .out_in_band(out_in_band),
    .transient(transient), .fast_en(fast_en), .ms_tick(ms_tick),
    .high_line_sel(high_line_sel), .fast_active(fast_active)
  );

  // behavioural model: mode 0 idle, 1 waiting for crossing, 2 fast, 3 leaving
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_high = 0; m_cnt = 0; m_mode = 0; m_ms = 0;
    end else begin
      if (zero_cross && m_cnt >= 8) begin
        m_high = !m_high; m_cnt = 0;
      end else if (rms_valid) begin
        if ((rms_value >= line_thresh) != m_high) begin
          if (m_cnt < 8) m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end
      if (!fast_en) m_mode = 0;
      else if (m_mode == 0) begin
        if (transient) m_mode = 1;
      end else if (m_mode == 1) begin
        if (zero_cross) begin m_mode = 2; m_ms = 0; end
      end else if (m_mode == 2) begin
        if (ms_tick) m_ms = m_ms + 1;
        if (out_in_band || m_ms >= TMO) m_mode = 3;
      end else begin
        if (zero_cross) m_mode = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (high_line_sel !== m_high) begin
        errors++;
        $display("FAIL R5 model line select: got %0d expected %0d at %0t", high_line_sel, m_high, $time);
      end
      checks++;
      if (fast_active !== (m_mode >= 2)) begin
        errors++;
        $display("FAIL R6 model fast flag: got %0d expected %0d at %0t", fast_active, (m_mode >= 2), $time);
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic strobe(input int v);
    @(negedge clk); rms_value = W'(v); rms_valid = 1'b1;
    @(negedge clk); rms_valid = 1'b0;
  endtask

  task automatic zc_pulse;
    @(negedge clk); zero_cross = 1'b1;
    @(negedge clk); zero_cross = 1'b0;
  endtask

  task automatic tr_pulse;
    @(negedge clk); transient = 1'b1;
    @(negedge clk); transient = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1 line select in reset", high_line_sel, 1'b0);
    chk("R1 fast flag in reset", fast_active, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    chk("R1 line select after reset", high_line_sel, 1'b0);
    chk("R1 fast flag after reset", fast_active, 1'b0);

    // debounce: seven differing strobes are not enough
    for (int i = 0; i < 7; i++) begin strobe(150); zc_pulse(); end
    chk("R3 seven strobes keep low line", high_line_sel, 1'b0);
    // a matching strobe cancels, then seven more still insufficient
    strobe(50);
    for (int i = 0; i < 7; i++) strobe(150);
    zc_pulse();
    chk("R4 cancel restarts count", high_line_sel, 1'b0);
    strobe(150);
    idle(3);
    chk("R5 armed but no crossing yet", high_line_sel, 1'b0);
    @(negedge clk); rms_value = 12'd20;
    idle(2);
    chk("R2 value without strobe ignored", high_line_sel, 1'b0);
    zc_pulse();
    chk("R5 switch to high at crossing", high_line_sel, 1'b1);

    // equality counts as high: no change pending
    for (int i = 0; i < 8; i++) strobe(100);
    zc_pulse();
    chk("R2 threshold equal is high class", high_line_sel, 1'b1);
    // armed, then cancelled by a matching strobe
    for (int i = 0; i < 8; i++) strobe(99);
    strobe(300);
    zc_pulse();
    chk("R4 armed change cancelled", high_line_sel, 1'b1);
    for (int i = 0; i < 8; i++) strobe(99);
    zc_pulse();
    chk("R5 switch back to low", high_line_sel, 1'b0);

    // fast loop entry and exit
    @(negedge clk); fast_en = 1'b1;
    tr_pulse();
    idle(3);
    chk("R6 no entry before crossing", fast_active, 1'b0);
    zc_pulse();
    chk("R6 entry at crossing", fast_active, 1'b1);
    @(negedge clk); out_in_band = 1'b1;
    idle(3);
    chk("R7 in band holds until crossing", fast_active, 1'b1);
    zc_pulse();
    chk("R7 exit at crossing", fast_active, 1'b0);
    @(negedge clk); out_in_band = 1'b0;

    // timeout
    tr_pulse();
    zc_pulse();
    chk("R8 fast entered for timeout", fast_active, 1'b1);
    @(negedge clk); ms_tick = 1'b1;
    idle(628);
    @(negedge clk); ms_tick = 1'b0;
    zc_pulse();
    chk("R8 after 629 ticks still fast", fast_active, 1'b1);
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    idle(2);
    chk("R8 expired waits for crossing", fast_active, 1'b1);
    zc_pulse();
    chk("R8 timeout exit at crossing", fast_active, 1'b0);

    // disable
    tr_pulse();
    zc_pulse();
    chk("R9 fast before disable", fast_active, 1'b1);
    @(negedge clk); fast_en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears fast flag", fast_active, 1'b0);
    tr_pulse();
    zc_pulse();
    idle(2);
    chk("R9 transient ignored when disabled", fast_active, 1'b0);

    idle(5);
    finish_run();
  end
endmodule